// File: doc/BRIEF.md
# Sequential Magnitude Approximation Unit

This block estimates the Euclidean length of a two-component vector, sqrt(a*a + b*b), without any multiplier or square-root hardware. It takes two signed two's-complement operands, forms their absolute values, and orders them so that x is the larger magnitude and y the smaller. It then evaluates the shift-add estimate 0.875x + 0.5y and returns the larger of that estimate and x. The fraction 0.875x is formed as x minus x shifted right by three, and 0.5y as y shifted right by one. Both shifts truncate toward zero.

The unit is a finite-state machine with a datapath. A controller steps through six named states, and one datapath operation runs per state. Only three datapath registers are used. Two operand registers first hold the raw inputs, then the magnitudes, then the sorted pair. The second operand register is reused for the intermediate sum. A third register holds the result. A caller pulses `start` with the operands present. One result is computed at a time. `done` pulses for one cycle when `result` becomes valid, and `result` keeps its value until the next computation finishes.

The states and their transitions are as follows:
- ST_IDLE waits for `start` and latches both operands, moving to ST_ABS.
- ST_ABS replaces each register with its magnitude, moving to ST_SORT.
- ST_SORT swaps the registers when needed, moving to ST_SHIFTADD.
- ST_SHIFTADD writes the estimate into the second register, moving to ST_MAX.
- ST_MAX loads the result register, moving to ST_DONE.
- ST_DONE raises `done` and moves back to ST_IDLE.

Top module: `mag_approx`

## Requirements
- R1: While reset (`rst_n` low) is applied and after its release, `done` is 0 and `result` is 0 until the first computation completes.
- R2: A `start` sampled high in the idle state latches `a_in` and `b_in`. `done` is then high in the fifth cycle after that clock edge, and for exactly one cycle.
- R3: Operands are W-bit two's complement (default W = 16). The magnitude of the most negative value, -2^(W-1), is taken exactly as 2^(W-1), with no saturation.
- R4: x is the larger magnitude and y the smaller. Swapping `a_in` and `b_in` gives the same `result`.
- R5: The intermediate estimate equals x - floor(x/8) + floor(y/2), computed on unsigned magnitudes.
- R6: `result` is the larger of the intermediate estimate and x, as a W-bit unsigned value. It never overflows, because its largest possible value is below 2^W.
- R7: A `start` raised while a computation is in progress has no effect. The running result is unchanged, and only one `done` pulse is produced.
- R8: `result` holds its value from one `done` pulse until the next computation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a computation when the unit is idle |
| a_in | input | W | First signed operand |
| b_in | input | W | Second signed operand |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | W | Unsigned magnitude estimate |

## Verification
The assertions assume that `start` is the only thing that can move the controller out of idle. They also assume that operand values matter only at the cycle `start` is sampled. Given that, they can claim that the sorted pair is ordered, that the intermediate sum never carries out of W bits, and that the result lies between x and 1.5x. The bench holds operands steady only across the start edge. It then overwrites them, and at times re-pulses `start`, while the unit is busy. This shows that the datapath depends on nothing but the latched copy. Random operands are drawn over the full signed range, and directed cases add zero, equal magnitudes, mixed signs and the most negative value.

// File: rtl/mag_pkg.sv
package mag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ABS      = 3'd1,
        ST_SORT     = 3'd2,
        ST_SHIFTADD = 3'd3,
        ST_MAX      = 3'd4,
        ST_DONE     = 3'd5
    } mag_state_e;

    // One strobe per datapath step, driven by the controller.
    typedef struct packed {
        logic load;   // capture raw operands
        logic absv;   // replace operands with magnitudes
        logic sort;   // order operands, larger first
        logic sum;    // write shift-add estimate into second register
        logic pick;   // load result with larger of estimate and x
    } mag_ctl_t;

endpackage

// File: rtl/mag_abs.sv
module mag_abs #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] mag_o
);
    // Two's-complement negate read back as unsigned: -2^(W-1) maps to 2^(W-1).
    always_comb begin
        if (val_i[W-1]) begin
            mag_o = ~val_i + 1'b1;
        end else begin
            mag_o = val_i;
        end
    end
endmodule

// File: rtl/mag_ctrl.sv
module mag_ctrl
    import mag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output mag_ctl_t ctl,
    output logic     done
);
    mag_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_ABS;
            ST_ABS:      state_nx = ST_SORT;
            ST_SORT:     state_nx = ST_SHIFTADD;
            ST_SHIFTADD: state_nx = ST_MAX;
            ST_MAX:      state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ctl  = '0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:     ctl.load = start;
            ST_ABS:      ctl.absv = 1'b1;
            ST_SORT:     ctl.sort = 1'b1;
            ST_SHIFTADD: ctl.sum  = 1'b1;
            ST_MAX:      ctl.pick = 1'b1;
            ST_DONE:     done     = 1'b1;
            default:     ctl      = '0;
        endcase
    end

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_ABS)); // R7
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_ABS)); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.load, ctl.absv, ctl.sort, ctl.sum, ctl.pick, done})); // R2
endmodule

// File: rtl/mag_dp.sv
module mag_dp
    import mag_pkg::*;
#(
    parameter int W       = 16,
    parameter int X_SHIFT = 3,
    parameter int Y_SHIFT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mag_ctl_t     ctl,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    localparam int SW = W + 1;
    localparam int NOPS = 2;

    // Shared registers: raw -> magnitude -> sorted; rb later holds the sum.
    logic [W-1:0] ra, rb, res;
    logic [W-1:0] opnd [NOPS];
    logic [W-1:0] mags [NOPS];
    logic         swap;
    logic [SW-1:0] sum_w;

    assign opnd[0] = ra;
    assign opnd[1] = rb;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_abs
        mag_abs #(.W(W)) u_abs (
            .val_i (opnd[gi]),
            .mag_o (mags[gi])
        );
    end

    always_comb begin
        swap  = (ra < rb);
        sum_w = {1'b0, ra} - ({1'b0, ra} >> X_SHIFT) + ({1'b0, rb} >> Y_SHIFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra  <= '0;
            rb  <= '0;
            res <= '0;
        end else begin
            if (ctl.load) begin
                ra <= a_i;
                rb <= b_i;
            end
            if (ctl.absv) begin
                ra <= mags[0];
                rb <= mags[1];
            end
            if (ctl.sort && swap) begin
                ra <= rb;
                rb <= ra;
            end
            if (ctl.sum) begin
                rb <= sum_w[W-1:0];
            end
            if (ctl.pick) begin
                res <= (rb > ra) ? rb : ra;
            end
        end
    end

    assign res_o = res;

    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sort |=> (ra >= rb)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sum |-> (sum_w[W] == 1'b0)); // R6
    AST_RESULT_AT_LEAST_X: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pick |=> (res >= ra)); // R6
    AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pick |=> ({1'b0, res} <= ({1'b0, ra} + ({1'b0, ra} >> 1)))); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.pick |=> $stable(res)); // R8
endmodule

// File: rtl/mag_approx.sv
module mag_approx
    import mag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic         done,
    output logic [W-1:0] result
);
    mag_ctl_t ctl;

    mag_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctl   (ctl),
        .done  (done)
    );

    mag_dp #(.W(W), .X_SHIFT(3), .Y_SHIFT(1)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .a_i   (a_in),
        .b_i   (b_in),
        .res_o (result)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_AFTER_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pick |=> done); // R2
endmodule

// File: tb/mag_approx_test.sv
`timescale 1ns/1ps
module mag_approx_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         done;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mag_approx #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in), .done(done), .result(result)
    );

    function automatic int mag_of(input logic [W-1:0] v);
        int s;
        s = int'($signed(v));
        return (s < 0) ? -s : s;
    endfunction

    function automatic int ref_mag(input logic [W-1:0] a, input logic [W-1:0] b);
        int ma, mb, x, y, t;
        ma = mag_of(a);
        mb = mag_of(b);
        x = (ma > mb) ? ma : mb;
        y = (ma > mb) ? mb : ma;
        t = x - (x / 8) + (y / 2);
        return (t > x) ? t : x;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one computation; optionally disturbs inputs and start while busy.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit disturb, input string req);
        int cyc;
        int exp;
        exp = ref_mag(a, b);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a_in = ~a; b_in = a ^ b;
        cyc = 1;
        while (!done && cyc < 20) begin
            if (disturb && cyc == 2) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check({req, " R2 latency"}, cyc, 5);
        check({req, " result"}, int'(result), exp);
        @(negedge clk);
        check("R2 done one cycle", int'(done), 0);
        check("R8 result held", int'(result), exp);
        if (disturb) begin
            repeat (6) begin
                @(negedge clk);
                check("R7 no second done", int'(done), 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ra, rb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset done", int'(done), 0);
        check("R1 reset result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle done", int'(done), 0);
        check("R1 idle result", int'(result), 0);

        run(16'd0, 16'd0, 0, "R6 zero");
        run(16'd100, 16'd100, 0, "R5 equal");
        run(16'hFF9C, 16'd100, 0, "R3 mixed sign");
        run(16'h8000, 16'd0, 0, "R3 most negative");
        run(16'h8000, 16'h8000, 0, "R6 both most negative");
        run(16'h8000, 16'h7FFF, 0, "R3 extreme pair");
        run(16'd8, 16'd1, 0, "R5 small truncation");
        run(16'd3, 16'd40, 0, "R4 swapped order");
        run(16'd40, 16'd3, 0, "R4 natural order");
        run(16'd1, 16'd0, 0, "R6 x dominates");
        run(16'd1000, 16'hFC18, 1, "R7 busy restart");

        for (int i = 0; i < 150; i++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            if (i % 10 == 0) rb = ra;
            if (i % 10 == 1) rb = -ra;
            run(ra, rb, (i % 7 == 0), "R5 R6 random");
            if (i % 25 == 0) run(rb, ra, 0, "R4 random swap");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule